// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block produces the instruction fetch address of a small 8-bit-data microcontroller core. It holds a 13-bit program counter, a 5-bit page register that software writes from the data bus, and an 8-entry return-address stack 13 bits wide. The counter's upper five bits cannot be written directly. They only change when the counter is loaded, and the new upper bits are then taken from the page register. A computed write to the low byte takes all five page bits. An absolute jump or a call carries an 11-bit immediate and takes only the top two page bits.

The instruction decoder drives one strobe per load kind: return, call, jump and low-byte write. If no strobe is active, the counter steps by one. A call saves the address of the next instruction on the stack. Any return restores the whole counter from the top of the stack. The stack is circular and has no error flags. All inputs are plain control and data pins that are sampled on every rising clock edge. The block has no streaming interface, so it applies no back-pressure and has no handshake.

Top module: `prog_addr_unit`

## Requirements
- R1: While `rst_n` is low, `fetch_addr` and `pc_low` read zero. Reset also clears the page register and the stack pointer.
- R2: With no strobe active, `fetch_addr` increases by one on each clock and wraps from 0x1FFF to 0x0000.
- R3: A low-byte write loads `{page[4:0], alu_result[7:0]}` into the counter.
- R4: A jump loads `{page[4:3], imm[10:0]}` into the counter.
- R5: A call loads the counter the same way as a jump. It also pushes the current `fetch_addr + 1` onto the stack.
- R6: A return loads all 13 bits of the counter from the top of the stack and pops that entry.
- R7: Nested calls up to eight deep return their addresses in last-in, first-out order.
- R8: A ninth push overwrites the oldest entry. Pops past empty wrap around the ring without any error indication. After nine calls, nine returns give the return addresses of calls 9, 8, …, 2 and then call 9 again.
- R9: A page write stores `page_din[4:0]` and ignores bits 7:5. The new value is first used on the next clock, so a load in the same cycle still uses the old value. The page register never takes bits from the counter.
- R10: When several strobes are active, return wins over call, call over jump, and jump over low-byte write. A return issued together with a call does not push.
- R11: `pc_low` always equals `fetch_addr[7:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| page_we | input | 1 | Write strobe for the page register |
| page_din | input | 8 | Data bus value for the page register |
| low_we | input | 1 | Computed write to the counter's low byte |
| alu_result | input | 8 | New low byte for a computed write |
| jump_en | input | 1 | Absolute jump strobe |
| call_en | input | 1 | Subroutine call strobe |
| ret_en | input | 1 | Return strobe, used for any of the return kinds |
| imm | input | 11 | Opcode immediate target |
| fetch_addr | output | 13 | Current program counter |
| pc_low | output | 8 | Low byte of the counter, for readback |

## Verification
A wrong counter value shows up on `fetch_addr` on the very next clock, so counter faults can be caught cycle by cycle. A wrong page register stays hidden until the next low-byte write, jump or call, which may be many cycles later. The bench therefore loads the page register and then tests every load kind against it, including a page write in the same cycle as a load. Stack corruption, such as a wrong pointer after wraparound or a push during a combined call-and-return, is only visible when a later return pops the entry. For this reason the bench nests nine calls and then unwinds them past empty.

// File: rtl/pau_pkg.sv
package pau_pkg;
  typedef enum logic [2:0] {
    SRC_INC  = 3'd0,
    SRC_LOW  = 3'd1,
    SRC_JMP  = 3'd2,
    SRC_CALL = 3'd3,
    SRC_RET  = 3'd4
  } pc_src_e;
endpackage

// File: rtl/pau_src_sel.sv
module pau_src_sel
  import pau_pkg::*;
(
  input  logic    ret_en,
  input  logic    call_en,
  input  logic    jump_en,
  input  logic    low_we,
  output pc_src_e src
);
  // Fixed priority: return, call, jump, low-byte write, increment (R10)
  always_comb begin
    if (ret_en)       src = SRC_RET;
    else if (call_en) src = SRC_CALL;
    else if (jump_en) src = SRC_JMP;
    else if (low_we)  src = SRC_LOW;
    else              src = SRC_INC;
  end
endmodule

// File: rtl/pau_page_latch.sv
module pau_page_latch #(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] din,
  output logic [PAGE_W-1:0] page
);
  // Written only from the data bus, never from the counter (R9)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  page <= '0;
    else if (we) page <= din[PAGE_W-1:0];
  end
endmodule

// File: rtl/pau_ret_stack.sv
module pau_ret_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_data,
  output logic [W-1:0] top
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PTR_W-1:0] sp;
  logic [PTR_W-1:0] top_idx;
  logic [W-1:0]     entry [DEPTH];

  assign top_idx = sp - PTR_W'(1);
  assign top     = entry[top_idx];

  // Ring pointer: wraps silently in both directions (R8)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sp <= '0;
    else if (pop)  sp <= top_idx;
    else if (push) sp <= sp + PTR_W'(1);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (push && !pop && (sp == PTR_W'(g))) entry[g] <= push_data;
    end
  end
endmodule

// File: rtl/prog_addr_unit.sv
module prog_addr_unit
  import pau_pkg::*;
#(
  parameter int PC_W    = 13,
  parameter int LOW_W   = 8,
  parameter int IMM_W   = 11,
  parameter int DATA_W  = 8,
  parameter int STACK_D = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_we,
  input  logic [DATA_W-1:0] page_din,
  input  logic              low_we,
  input  logic [LOW_W-1:0]  alu_result,
  input  logic              jump_en,
  input  logic              call_en,
  input  logic              ret_en,
  input  logic [IMM_W-1:0]  imm,
  output logic [PC_W-1:0]   fetch_addr,
  output logic [LOW_W-1:0]  pc_low
);
  localparam int PAGE_W = PC_W - LOW_W;
  localparam int JHI_W  = PC_W - IMM_W;

  pc_src_e           src;
  logic [PAGE_W-1:0] page;
  logic [PC_W-1:0]   pc_q;
  logic [PC_W-1:0]   pc_d;
  logic [PC_W-1:0]   pc_inc;
  logic [PC_W-1:0]   stack_top;

  pau_src_sel u_sel (
    .ret_en  (ret_en),
    .call_en (call_en),
    .jump_en (jump_en),
    .low_we  (low_we),
    .src     (src)
  );

  pau_page_latch #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_page (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (page_we),
    .din   (page_din),
    .page  (page)
  );

  assign pc_inc = pc_q + PC_W'(1);

  pau_ret_stack #(.DEPTH(STACK_D), .W(PC_W)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (src == SRC_CALL),
    .pop       (src == SRC_RET),
    .push_data (pc_inc),
    .top       (stack_top)
  );

  always_comb begin
    unique case (src)
      SRC_RET:           pc_d = stack_top;
      SRC_CALL, SRC_JMP: pc_d = {page[PAGE_W-1 -: JHI_W], imm};
      SRC_LOW:           pc_d = {page, alu_result};
      default:           pc_d = pc_inc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign fetch_addr = pc_q;
  assign pc_low     = pc_q[LOW_W-1:0];
endmodule

// File: rtl/prog_addr_unit_chk.sv
module prog_addr_unit_chk #(
  parameter int PC_W  = 13,
  parameter int LOW_W = 8,
  parameter int IMM_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             low_we,
  input logic [LOW_W-1:0] alu_result,
  input logic             jump_en,
  input logic             call_en,
  input logic             ret_en,
  input logic [IMM_W-1:0] imm,
  input logic [PC_W-1:0]  fetch_addr,
  input logic [LOW_W-1:0] pc_low
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (fetch_addr == '0));

  assert_step_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_en && !call_en && !jump_en && !low_we)
      |=> (fetch_addr == PC_W'($past(fetch_addr) + PC_W'(1))));

  assert_low_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (low_we && !jump_en && !call_en && !ret_en) |=> (pc_low == $past(alu_result)));

  assert_jump_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((jump_en || call_en) && !ret_en) |=> (fetch_addr[IMM_W-1:0] == $past(imm)));

  // R6 and R10: a return right after a call restores the address after the call
  assert_call_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_en && $past(call_en && !ret_en))
      |=> (fetch_addr == PC_W'($past(fetch_addr, 2) + PC_W'(1))));
endmodule

bind prog_addr_unit prog_addr_unit_chk #(
  .PC_W(PC_W), .LOW_W(LOW_W), .IMM_W(IMM_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .low_we(low_we), .alu_result(alu_result),
  .jump_en(jump_en), .call_en(call_en), .ret_en(ret_en), .imm(imm),
  .fetch_addr(fetch_addr), .pc_low(pc_low)
);

// File: tb/prog_addr_unit_tb.sv
`timescale 1ns/1ps
module prog_addr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        page_we = 1'b0;
  logic [7:0]  page_din = '0;
  logic        low_we = 1'b0;
  logic [7:0]  alu_result = '0;
  logic        jump_en = 1'b0;
  logic        call_en = 1'b0;
  logic        ret_en = 1'b0;
  logic [10:0] imm = '0;
  logic [12:0] fetch_addr;
  logic [7:0]  pc_low;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  prog_addr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .page_we(page_we), .page_din(page_din),
    .low_we(low_we), .alu_result(alu_result), .jump_en(jump_en),
    .call_en(call_en), .ret_en(ret_en), .imm(imm),
    .fetch_addr(fetch_addr), .pc_low(pc_low)
  );

  typedef struct packed {
    logic        pw;
    logic [7:0]  pd;
    logic        lw;
    logic [7:0]  alu;
    logic        j;
    logic        c;
    logic        r;
    logic [10:0] im;
    logic [12:0] exp_pc;
  } vec_t;

  // Walked from reset: counter 0, page 0, stack empty
  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 11'h000, 13'h0001}, // R2
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 11'h000, 13'h0002}, // R2
    '{1'b1, 8'hFD, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 11'h000, 13'h0003}, // R9 page=1D
    '{1'b0, 8'h00, 1'b1, 8'h40, 1'b0, 1'b0, 1'b0, 11'h000, 13'h1D40}, // R3
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 11'h000, 13'h1D41}, // R2
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 11'h123, 13'h1923}, // R4
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 11'h7FF, 13'h1FFF}, // R5 push 1924
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 11'h000, 13'h0000}, // R2 wrap
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 11'h000, 13'h1924}, // R6
    '{1'b1, 8'h08, 1'b1, 8'h10, 1'b0, 1'b0, 1'b0, 11'h000, 13'h1D10}, // R9 old page used
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 11'h005, 13'h0805}, // R9 R4 new page
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 11'h200, 13'h0A00}, // R5 push 0806
    '{1'b0, 8'h00, 1'b1, 8'hFF, 1'b1, 1'b1, 1'b0, 11'h300, 13'h0B00}, // R10 call wins, push 0A01
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 11'h111, 13'h0A01}, // R10 return wins
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 11'h000, 13'h0806}, // R10 no push happened
    '{1'b0, 8'h00, 1'b1, 8'h99, 1'b1, 1'b0, 1'b0, 11'h045, 13'h0845}, // R10 jump over low write
    '{1'b0, 8'h00, 1'b1, 8'hAB, 1'b0, 1'b0, 1'b0, 11'h000, 13'h08AB}  // R3
  };

  task automatic chk(input string req, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic idle();
    page_we = 0; low_we = 0; jump_en = 0; call_en = 0; ret_en = 0;
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst_n = 1'b0;
    #1;
    chk("R1 fetch_addr in reset", fetch_addr, 13'h0);
    chk("R11 pc_low in reset", {5'b0, pc_low}, 13'h0);
    cycle();
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [12:0] exp_pc;
    logic [12:0] pushed [1:9];
    do_reset();

    for (int i = 0; i < NV; i++) begin
      page_we = VEC[i].pw; page_din = VEC[i].pd;
      low_we = VEC[i].lw; alu_result = VEC[i].alu;
      jump_en = VEC[i].j; call_en = VEC[i].c; ret_en = VEC[i].r;
      imm = VEC[i].im;
      cycle();
      chk($sformatf("table row %0d fetch_addr", i), fetch_addr, VEC[i].exp_pc);
      chk($sformatf("R11 table row %0d pc_low", i), {5'b0, pc_low}, {5'b0, VEC[i].exp_pc[7:0]});
    end
    idle();

    // R1: reset mid-run clears the counter and the page register
    do_reset();
    low_we = 1; alu_result = 8'h33;
    cycle();
    idle();
    chk("R1 page cleared by reset", fetch_addr, 13'h0033);

    // R7 R8: nine nested calls, then nine returns
    do_reset();
    page_we = 1; page_din = 8'hE8;  // R9: bits 7:5 ignored, page = 0x08
    cycle();
    idle();
    exp_pc = 13'h0001;
    chk("R9 page write leaves counter stepping", fetch_addr, exp_pc);
    for (int k = 1; k <= 9; k++) begin
      pushed[k] = exp_pc + 13'd1;
      call_en = 1; imm = 11'(k * 16);
      cycle();
      exp_pc = 13'h0800 | 13'(k * 16);
      chk("R5 nested call target", fetch_addr, exp_pc);
    end
    call_en = 0;
    for (int k = 9; k >= 2; k--) begin
      ret_en = 1;
      cycle();
      chk($sformatf("R7 LIFO return %0d", k), fetch_addr, pushed[k]);
    end
    ret_en = 1;
    cycle();
    chk("R8 pop past empty wraps to newest", fetch_addr, pushed[9]);
    idle();

    // R2: step across the top of the address space
    page_we = 1; page_din = 8'h1F;
    cycle();
    idle();
    low_we = 1; alu_result = 8'hFE;
    cycle();
    idle();
    chk("R3 low write on top page", fetch_addr, 13'h1FFE);
    cycle();
    chk("R2 step to 1FFF", fetch_addr, 13'h1FFF);
    cycle();
    chk("R2 wrap to 0000", fetch_addr, 13'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule